// File: doc/BRIEF.md
# Four-Channel Blank-Timed DMA Controller

This block moves data between memory locations without processor involvement. It has four independent channels. Software programs each channel through a small register window with a source address, a destination address, a unit count and a control word. A channel can run as soon as it is enabled, or wait for a pulse that marks the start of a vertical or horizontal blanking interval. The controller moves halfwords or words over one memory master port, one unit at a time. Each unit is a read followed by a write.

Channel 0 has the highest priority and channel 3 the lowest. Arbitration is repeated after every unit. An urgent low-numbered channel can therefore interrupt a long copy on a higher-numbered channel, which resumes from its saved working addresses once the bus is free again. When a channel finishes its count, it can pulse its interrupt line. It then either turns itself off or reloads for its next trigger.

The transfer engine is a four-state machine:
- `ENG_IDLE`: picks the winning pending channel. It moves to `ENG_READ` when any channel is pending.
- `ENG_READ`: issues the read. It moves to `ENG_WRITE` on `mem_ready`.
- `ENG_WRITE`: issues the write of the data just read. On `mem_ready` it moves to `ENG_FINISH` if that was the channel's last unit, and otherwise back to `ENG_IDLE` for re-arbitration.
- `ENG_FINISH`: performs the channel's completion for one cycle, then returns to `ENG_IDLE`.

Top module: `dma4_ctrl`

## Requirements
- R1: `reg_addr[3:2]` selects the channel and `reg_addr[1:0]` the field (0 source, 1 destination, 2 count, 3 control); a write to source or destination stores the value with bit 0 forced to zero, and reads return the stored values.
- R2: A count of N moves N units; a count of 0 moves 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3.
- R3: Control bits [1:0] give the destination step and bits [3:2] the source step, coded 0 increment, 1 decrement, 2 fixed, 3 increment with destination reload; the step is 2 bytes when bit [5] is 0 (halfword) and 4 bytes when it is 1 (word).
- R4: With word width, bit 1 of the working source and destination is cleared when the working copies are loaded.
- R5: Working copies load, and an immediate start occurs, only when control bit [15] (enable) goes from 0 to 1; rewriting control with enable already 1 neither reloads nor restarts the channel.
- R6: Control bits [7:6] select the start: 0 immediate, 1 on a `vblank_start` pulse, 2 on an `hblank_start` pulse; a blank pulse services every enabled channel of matching start code in ascending channel order, and a pulse of the other kind has no effect.
- R7: A lower-numbered channel that becomes pending takes the port at the next unit boundary; the preempted channel later continues from its next unit.
- R8: When a channel with repeat (bit [4]) clear finishes, its enable bit reads back 0.
- R9: With repeat set, the count reloads, the source continues from its advanced value, the destination restarts only with step code 3, and the channel stays enabled awaiting its next trigger.
- R10: With bit [8] set, `irq[n]` pulses for exactly one cycle after channel n's last unit; with bit [8] clear no pulse occurs.
- R11: Start code 3 is accepted but no trigger ever starts a transfer on that channel.
- R12: Each unit is a read handshake followed by a write handshake carrying the data read; address and direction are held while `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel and field select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| vblank_start | input | 1 | One-cycle vertical blank start pulse |
| hblank_start | input | 1 | One-cycle horizontal blank start pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_word | output | 1 | 1 for word, 0 for halfword access |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Completes the current access |
| irq | output | 4 | Per-channel completion pulse |

## Verification
A corrupted working address shows up at the very next write handshake as a destination or data value off the computed sequence. A corrupted working count shows up as an early or late interrupt pulse and a wrong total number of writes. Arbitration faults appear as interleaved writes from two channels inside a single unit boundary, or as a lower channel waiting behind a higher one for more than one unit. Repeat and reload faults become visible on the second trigger, when the addresses either restart or continue incorrectly.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        STEP_INC        = 2'd0,
        STEP_DEC        = 2'd1,
        STEP_FIXED      = 2'd2,
        STEP_INC_RELOAD = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        START_NOW     = 2'd0,
        START_VBLANK  = 2'd1,
        START_HBLANK  = 2'd2,
        START_SPECIAL = 2'd3
    } start_mode_e;

    typedef struct packed {
        logic        enable;
        logic [5:0]  spare;
        logic        irq_en;
        start_mode_e start;
        logic        word;
        logic        repeat_en;
        step_mode_e  src_mode;
        step_mode_e  dst_mode;
    } chan_ctrl_t;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_READ   = 2'd1,
        ENG_WRITE  = 2'd2,
        ENG_FINISH = 2'd3
    } eng_state_e;

    localparam logic [1:0] FLD_SRC  = 2'd0;
    localparam logic [1:0] FLD_DST  = 2'd1;
    localparam logic [1:0] FLD_CNT  = 2'd2;
    localparam logic [1:0] FLD_CTRL = 2'd3;

endpackage

// File: rtl/dma4_channel.sv
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int CH_ID  = 0,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              step,
    input  logic              finish,
    output chan_ctrl_t        ctrl_q,
    output logic [ADDR_W-1:0] src_reg,
    output logic [ADDR_W-1:0] dst_reg,
    output logic [CNT_W-1:0]  cnt_reg,
    output logic [ADDR_W-1:0] src_work,
    output logic [ADDR_W-1:0] dst_work,
    output logic              last_unit,
    output logic              pending,
    output logic              irq
);

    localparam int WCNT = CNT_W + 1;
    localparam logic [WCNT-1:0] MAX_SHORT = WCNT'(1) << (CNT_W - 2);
    localparam logic [WCNT-1:0] MAX_LONG  = WCNT'(1) << CNT_W;
    localparam logic [WCNT-1:0] ZERO_MAX  = (CH_ID == NUM_CH - 1) ? MAX_LONG : MAX_SHORT;

    logic [WCNT-1:0] cnt_work;
    chan_ctrl_t      new_ctrl;
    logic            ctrl_wr;
    logic            arm;
    logic            disarm;
    logic            blank_hit;
    logic [ADDR_W-1:0] src_delta;
    logic [ADDR_W-1:0] dst_delta;

    function automatic logic [WCNT-1:0] expand(input logic [CNT_W-1:0] c);
        return (c == '0) ? ZERO_MAX : {1'b0, c};
    endfunction

    function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a, input logic word);
        return word ? (a & ~ADDR_W'(3)) : a;
    endfunction

    function automatic logic [ADDR_W-1:0] delta(input step_mode_e m, input logic word);
        logic [ADDR_W-1:0] sz;
        sz = word ? ADDR_W'(4) : ADDR_W'(2);
        unique case (m)
            STEP_INC, STEP_INC_RELOAD: return sz;
            STEP_DEC:                  return '0 - sz;
            default:                   return '0;
        endcase
    endfunction

    always_comb begin
        new_ctrl       = chan_ctrl_t'(wr_data[15:0]);
        new_ctrl.spare = '0;
    end

    assign ctrl_wr   = wr_en && (wr_fld == FLD_CTRL);
    assign arm       = ctrl_wr && new_ctrl.enable && !ctrl_q.enable;
    assign disarm    = ctrl_wr && !new_ctrl.enable;
    assign blank_hit = ctrl_q.enable &&
                       ((vblank && ctrl_q.start == START_VBLANK) ||
                        (hblank && ctrl_q.start == START_HBLANK));
    assign src_delta = delta(ctrl_q.src_mode, ctrl_q.word);
    assign dst_delta = delta(ctrl_q.dst_mode, ctrl_q.word);
    assign last_unit = (cnt_work == WCNT'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            src_reg  <= '0;
            dst_reg  <= '0;
            cnt_reg  <= '0;
            src_work <= '0;
            dst_work <= '0;
            cnt_work <= '0;
            pending  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= finish && ctrl_q.enable && ctrl_q.irq_en;
            if (step) begin
                src_work <= src_work + src_delta;
                dst_work <= dst_work + dst_delta;
                cnt_work <= cnt_work - WCNT'(1);
            end
            if (finish && ctrl_q.enable) begin
                if (ctrl_q.repeat_en) begin
                    cnt_work <= expand(cnt_reg);
                    if (ctrl_q.dst_mode == STEP_INC_RELOAD) begin
                        dst_work <= align(dst_reg, ctrl_q.word);
                    end
                    pending <= (ctrl_q.start == START_NOW);
                end else begin
                    ctrl_q.enable <= 1'b0;
                    pending       <= 1'b0;
                end
            end
            if (blank_hit) begin
                pending <= 1'b1;
            end
            if (wr_en) begin
                unique case (wr_fld)
                    FLD_SRC: src_reg <= wr_data & ~ADDR_W'(1);
                    FLD_DST: dst_reg <= wr_data & ~ADDR_W'(1);
                    FLD_CNT: cnt_reg <= wr_data[CNT_W-1:0];
                    default: ctrl_q  <= new_ctrl;
                endcase
            end
            if (arm) begin
                src_work <= align(src_reg, new_ctrl.word);
                dst_work <= align(dst_reg, new_ctrl.word);
                cnt_work <= expand(cnt_reg);
                pending  <= (new_ctrl.start == START_NOW);
            end
            if (disarm) begin
                pending <= 1'b0;
            end
        end
    end

    // R5
    pending_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> ctrl_q.enable)
        else $error("pending channel %0d is not enabled", CH_ID);

    // R8
    done_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && ctrl_q.enable && !ctrl_q.repeat_en && !ctrl_wr) |=> !ctrl_q.enable)
        else $error("channel %0d stayed enabled after a single run", CH_ID);

endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] pending,
    output logic              any,
    output logic [IDX_W-1:0]  pick
);

    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                any  = 1'b1;
                pick = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_pend,
    input  logic [IDX_W-1:0]  pick,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic              cur_word,
    input  logic              cur_last,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  sel,
    output logic              step,
    output logic              finish,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    eng_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (any_pend)  state_d = ENG_READ;
            ENG_READ:   if (mem_ready) state_d = ENG_WRITE;
            ENG_WRITE:  if (mem_ready) state_d = cur_last ? ENG_FINISH : ENG_IDLE;
            ENG_FINISH: state_d = ENG_IDLE;
            default:    state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            sel     <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENG_IDLE && any_pend) sel <= pick;
            if (state_q == ENG_READ && mem_ready) data_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_dst;
        step      = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ENG_READ: begin
                mem_req  = 1'b1;
                mem_addr = cur_src;
            end
            ENG_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = mem_ready;
            end
            ENG_FINISH: finish = 1'b1;
            default: ;
        endcase
        mem_word  = cur_word;
        mem_wdata = data_q;
    end

    // R12
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ready))
        else $error("write issued without a completed read");

    // R12
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("access changed while stalled");

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              vblank_start,
    input  logic              hblank_start,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] irq
);

    chan_ctrl_t        ctrl_a  [NUM_CH];
    logic [ADDR_W-1:0] srcr_a  [NUM_CH];
    logic [ADDR_W-1:0] dstr_a  [NUM_CH];
    logic [CNT_W-1:0]  cntr_a  [NUM_CH];
    logic [ADDR_W-1:0] srcw_a  [NUM_CH];
    logic [ADDR_W-1:0] dstw_a  [NUM_CH];
    logic [NUM_CH-1:0] last_v;
    logic [NUM_CH-1:0] pend_v;
    logic [IDX_W-1:0]  sel;
    logic [IDX_W-1:0]  pick;
    logic              any_pend;
    logic              step;
    logic              finish;
    logic [IDX_W-1:0]  rd_ch;

    assign rd_ch = reg_addr[RA_W-1:2];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma4_channel #(
            .CH_ID (g),
            .NUM_CH(NUM_CH),
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (rd_ch == IDX_W'(g))),
            .wr_fld   (reg_addr[1:0]),
            .wr_data  (reg_wdata),
            .vblank   (vblank_start),
            .hblank   (hblank_start),
            .step     (step && (sel == IDX_W'(g))),
            .finish   (finish && (sel == IDX_W'(g))),
            .ctrl_q   (ctrl_a[g]),
            .src_reg  (srcr_a[g]),
            .dst_reg  (dstr_a[g]),
            .cnt_reg  (cntr_a[g]),
            .src_work (srcw_a[g]),
            .dst_work (dstw_a[g]),
            .last_unit(last_v[g]),
            .pending  (pend_v[g]),
            .irq      (irq[g])
        );
    end

    dma4_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .pending(pend_v),
        .any    (any_pend),
        .pick   (pick)
    );

    dma4_engine #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .pick     (pick),
        .cur_src  (srcw_a[sel]),
        .cur_dst  (dstw_a[sel]),
        .cur_word (ctrl_a[sel].word),
        .cur_last (last_v[sel]),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .sel      (sel),
        .step     (step),
        .finish   (finish),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_word (mem_word),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    always_comb begin
        unique case (reg_addr[1:0])
            FLD_SRC: reg_rdata = srcr_a[rd_ch];
            FLD_DST: reg_rdata = dstr_a[rd_ch];
            FLD_CNT: reg_rdata = ADDR_W'(cntr_a[rd_ch]);
            default: reg_rdata = ADDR_W'(ctrl_a[rd_ch]);
        endcase
    end

    // R10
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |=> (irq == '0))
        else $error("interrupt pulse longer than one cycle");

    // R10
    irq_one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq))
        else $error("two channel interrupts at once");

endmodule

// File: tb/dma4_ctrl_tb_top.sv
module dma4_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vblank_start = 1'b0;
    logic        hblank_start = 1'b0;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [3:0]  irq;

    always #5 clk = ~clk;

    dma4_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vblank_start(vblank_start), .hblank_start(hblank_start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    localparam int LOGN = 1024;
    localparam logic [31:0] EN = 32'h8000, IEN = 32'h100, WORD = 32'h20, RPT = 32'h10;

    function automatic logic [31:0] memfun(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    function automatic logic [31:0] addr_at(input logic [31:0] b, input int mode, input bit word, input int i);
        int sz = word ? 4 : 2;
        case (mode)
            1: return b - 32'(i * sz);
            2: return b;
            default: return b + 32'(i * sz);
        endcase
    endfunction

    function automatic logic [31:0] ctl(input int dm, input int sm, input int st, input logic [31:0] flags);
        return flags | 32'(dm) | (32'(sm) << 2) | (32'(st) << 6);
    endfunction

    assign mem_rdata = memfun(mem_addr);

    logic [31:0] logA [LOGN];
    logic [31:0] logD [LOGN];
    int nwr = 0, cyc = 0, irq_err = 0, checks = 0, errs = 0;
    int irq_cnt [4] = '{0, 0, 0, 0};
    int irq_cyc [4] = '{0, 0, 0, 0};
    logic [3:0] irq_q = '0;
    bit rand_ready = 1'b1;
    bit done = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (mem_req && mem_ready && mem_we) begin
                if (nwr < LOGN) begin
                    logA[nwr] = mem_addr;
                    logD[nwr] = mem_wdata;
                end
                nwr = nwr + 1;
            end
            for (int c = 0; c < 4; c++) begin
                if (irq[c]) begin
                    irq_cnt[c] = irq_cnt[c] + 1;
                    irq_cyc[c] = cyc;
                end
            end
            if ((irq & irq_q) != '0) begin
                irq_err = irq_err + 1;
                $display("FAIL R10 irq held two cycles: actual=%h expected=0", irq & irq_q);
            end
            irq_q = irq;
        end
        mem_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;
        if (cyc > 190000 && !done) begin
            $display("FAIL watchdog expired: actual=%0d expected=<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 2, errs + irq_err + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errs = errs + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(ch * 4 + fld); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(ch * 4 + fld);
        #1 d = reg_rdata;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n);
    endtask

    task automatic wait_irq(input int c, input int target, input int tmo, input string tag);
        int n = 0;
        while (irq_cnt[c] < target && n < tmo) begin
            @(negedge clk); n++;
        end
        chk(irq_cnt[c] >= target, tag, 32'(irq_cnt[c]), 32'(target));
    endtask

    task automatic pulse(input bit v);
        @(negedge clk);
        if (v) vblank_start = 1'b1; else hblank_start = 1'b1;
        @(negedge clk);
        vblank_start = 1'b0; hblank_start = 1'b0;
    endtask

    task automatic check_seq(input int first, input int n, input logic [31:0] s0, input int sm,
                             input logic [31:0] d0, input int dm, input bit word, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [31:0] es, ed;
            es = addr_at(s0, sm, word, i);
            ed = addr_at(d0, dm, word, i);
            chk(logA[first + i] == ed, {tag, " dest"}, logA[first + i], ed);
            chk(logD[first + i] == memfun(es), {tag, " data"}, logD[first + i], memfun(es));
        end
    endtask

    initial begin
        logic [31:0] v;
        int base, i0, i3, nen, first0, n0, n3;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        for (int c = 0; c < 4; c++) begin
            rd(c, 3, v);
            chk(v == 0, "reset control R8", v, 0);
        end
        chk(mem_req == 1'b0, "reset mem_req R12", 32'(mem_req), 0);
        chk(irq == 4'b0, "reset irq R10", 32'(irq), 0);

        // R1: bit 0 cleared on address writes
        wr(1, 0, 32'h0000_1235); rd(1, 0, v);
        chk(v == 32'h0000_1234, "R1 source bit0", v, 32'h1234);
        wr(1, 1, 32'hABCD_0003); rd(1, 1, v);
        chk(v == 32'hABCD_0002, "R1 dest bit0", v, 32'hABCD0002);

        // R3 R10 R8 R12: immediate halfword increment on channel 2
        base = nwr;
        setup(2, 32'h1100, 32'h8100, 5);
        wr(2, 3, ctl(0, 0, 0, EN | IEN));
        wait_irq(2, 1, 500, "R10 ch2 irq");
        chk(nwr - base == 5, "R2 count 5 units", 32'(nwr - base), 5);
        check_seq(base, 5, 32'h1100, 0, 32'h8100, 0, 0, "R3 R12 halfword inc");
        rd(2, 3, v);
        chk(v[15] == 1'b0, "R8 enable cleared", v, 0);

        // R3 R4: word, source decrement, dest fixed, bit 1 set in addresses
        base = nwr;
        setup(2, 32'h1006, 32'h8402, 4);
        wr(2, 3, ctl(2, 1, 0, EN | IEN | WORD));
        wait_irq(2, 2, 500, "R10 ch2 irq word");
        chk(nwr - base == 4, "R2 count 4 units", 32'(nwr - base), 4);
        check_seq(base, 4, 32'h1004, 1, 32'h8400, 2, 1, "R3 R4 word dec/fixed");
        chk(mem_word == 1'b1, "R3 word size output", 32'(mem_word), 1);

        // R5: rewriting enable does not reload working copies
        base = nwr;
        setup(0, 32'h2000, 32'h8500, 2);
        wr(0, 3, ctl(0, 0, 1, EN | IEN));
        wr(0, 0, 32'h2800); wr(0, 1, 32'h8600);
        wr(0, 3, ctl(0, 0, 1, EN | IEN));
        repeat (20) @(negedge clk);
        chk(nwr == base, "R5 no restart on rewrite", 32'(nwr - base), 0);
        pulse(1'b1);
        wait_irq(0, 1, 500, "R10 ch0 irq");
        check_seq(base, 2, 32'h2000, 0, 32'h8500, 0, 0, "R5 old working copy");
        rd(0, 3, v);
        chk(v[15] == 1'b0, "R8 ch0 enable cleared", v, 0);

        // R6 R9: two vblank repeat channels, wrong blank kind ignored
        base = nwr;
        setup(1, 32'h4000, 32'h8700, 3);
        wr(1, 3, ctl(3, 0, 1, EN | IEN | RPT));
        setup(2, 32'h5000, 32'h8800, 2);
        wr(2, 3, ctl(0, 0, 1, EN | IEN | RPT));
        pulse(1'b0);
        repeat (30) @(negedge clk);
        chk(nwr == base, "R6 hblank ignored", 32'(nwr - base), 0);
        pulse(1'b1);
        wait_irq(2, 3, 500, "R6 ch2 serviced");
        chk(irq_cyc[1] < irq_cyc[2], "R6 ascending order", 32'(irq_cyc[1]), 32'(irq_cyc[2]));
        chk(nwr - base == 5, "R6 both serviced", 32'(nwr - base), 5);
        check_seq(base, 3, 32'h4000, 0, 32'h8700, 3, 0, "R6 ch1 first run");
        check_seq(base + 3, 2, 32'h5000, 0, 32'h8800, 0, 0, "R6 ch2 first run");
        rd(1, 3, v);
        chk(v[15] == 1'b1, "R9 stays enabled", v, 32'h8000);
        base = nwr;
        pulse(1'b1);
        wait_irq(2, 4, 500, "R9 ch2 second irq");
        check_seq(base, 3, 32'h4006, 0, 32'h8700, 3, 0, "R9 ch1 dest reload");
        check_seq(base + 3, 2, 32'h5004, 0, 32'h8804, 0, 0, "R9 ch2 dest continues");
        wr(1, 3, 0); wr(2, 3, 0);

        // R11: special start code
        base = nwr;
        setup(0, 32'h6000, 32'h8A00, 2);
        wr(0, 3, ctl(0, 0, 3, EN | IEN));
        setup(1, 32'h6100, 32'h8B00, 2);
        wr(1, 3, ctl(0, 0, 3, EN | IEN));
        repeat (20) @(negedge clk);
        pulse(1'b1); pulse(1'b0);
        repeat (30) @(negedge clk);
        chk(nwr == base, "R11 special never runs", 32'(nwr - base), 0);
        wr(0, 3, 0); wr(1, 3, 0);

        // R7: channel 0 preempts channel 3 at a unit boundary
        base = nwr;
        setup(0, 32'h7000, 32'h8000, 2);
        setup(3, 32'h3000, 32'h9000, 20);
        wr(3, 3, ctl(0, 0, 0, EN | IEN));
        while (nwr - base < 4) @(negedge clk);
        nen = nwr;
        wr(0, 3, ctl(0, 0, 0, EN | IEN));
        wait_irq(3, 1, 2000, "R7 ch3 completes");
        chk(irq_cyc[0] < irq_cyc[3], "R7 ch0 finishes first", 32'(irq_cyc[0]), 32'(irq_cyc[3]));
        first0 = -1; n0 = 0; n3 = 0;
        for (int i = base; i < nwr; i++) begin
            if (logA[i][15:12] == 4'h8) begin
                if (first0 < 0) first0 = i;
                i0 = i;
                chk(i == first0 + n0, "R7 ch0 units back to back", 32'(i), 32'(first0 + n0));
                n0++;
            end else begin
                i3 = i;
                chk(logA[i] == 32'h9000 + 32'(2 * n3), "R7 ch3 resumes in order", logA[i], 32'h9000 + 32'(2 * n3));
                chk(logD[i] == memfun(32'h3000 + 32'(2 * n3)), "R7 ch3 data", logD[i], memfun(32'h3000 + 32'(2 * n3)));
                n3++;
            end
        end
        chk(n0 == 2 && n3 == 20, "R7 unit totals", 32'(n0 * 256 + n3), 32'(2 * 256 + 20));
        chk(first0 <= nen + 2, "R7 preempt at next boundary", 32'(first0), 32'(nen + 2));
        chk(i3 > i0, "R7 ch3 continues after ch0", 32'(i3), 32'(i0));

        // R10: no pulse with interrupt enable clear
        base = nwr;
        setup(3, 32'h3100, 32'h9100, 2);
        wr(3, 3, ctl(0, 0, 0, EN));
        repeat (40) @(negedge clk);
        chk(nwr - base == 2, "R10 silent run moved", 32'(nwr - base), 2);
        chk(irq_cnt[3] == 1, "R10 no irq without enable", 32'(irq_cnt[3]), 1);
        rd(3, 3, v);
        chk(v[15] == 1'b0, "R8 ch3 enable cleared", v, 0);

        // R2: zero count expansion
        rand_ready = 1'b0;
        base = nwr;
        setup(3, 32'h3200, 32'h9200, 0);
        wr(3, 3, ctl(2, 2, 0, EN | IEN));
        begin
            int n = 0;
            while (nwr - base < 16386 && n < 60000) begin @(negedge clk); n++; end
        end
        chk(nwr - base >= 16386, "R2 ch3 runs past 0x4000", 32'(nwr - base), 16386);
        chk(irq_cnt[3] == 1, "R2 ch3 not finished at 0x4000", 32'(irq_cnt[3]), 1);
        rd(3, 3, v);
        chk(v[15] == 1'b1, "R2 ch3 still enabled", v, 32'h8000);
        wr(3, 3, 0);
        repeat (10) @(negedge clk);
        base = nwr;
        setup(1, 32'h4200, 32'h9400, 0);
        wr(1, 3, ctl(2, 2, 0, EN | IEN));
        wait_irq(1, 3, 60000, "R2 ch1 completes");
        repeat (5) @(negedge clk);
        chk(nwr - base == 16384, "R2 ch1 zero count is 0x4000", 32'(nwr - base), 16384);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errs + irq_err);
        $finish;
    end

endmodule